// File: doc/BRIEF.md
# Scatter-Gather Region Table Walker

This block is a bus-master DMA sequencer. It moves a buffer of a known byte count between the device side and host memory. The host memory side is described by a table of region descriptors. A start pulse gives the table base, the direction and the byte count. The walker then fetches each descriptor as two 32-bit reads and decodes the region it describes. It issues data-movement requests that split the buffer across the regions.

Every memory access goes through one request channel, with a single request in flight at a time. Each request is tagged as a descriptor-word read or a data chunk. A data chunk carries the region address, its byte length and the transfer direction. The memory side returns one response per accepted request; for descriptor reads the response carries the word.

The walk stops for one of two reasons:
- The whole buffer has been moved. The block then pulses `done`.
- The table ran out first, either through the final-entry flag or through a one-page fail-safe on the table pointer. The block then pulses `incomplete`.

Top module: `sg_table_walker`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `incomplete` and `mem_req_valid` are all low.
- R2: A `start` pulse seen while idle latches base, direction and count and raises `busy` one cycle later. A `start` seen while busy is ignored and leaves the running request sequence unchanged.
- R3: A descriptor is fetched as two 4-byte reads, with `mem_req_data`=0, `mem_req_write`=0 and `mem_req_len`=4. The first read, at the table pointer, gives the region address. The second read, at pointer+4, gives the size/flags word. The pointer then advances by 8.
- R4: Region length is size word bits [15:1] with bit 0 forced to zero. A zero result means 65536 bytes. Bits [30:16] and bit 0 have no effect.
- R5: Bit 31 of the size word marks the final entry. Once that region is used up, no further descriptor is fetched.
- R6: Once the table pointer is 4096 or more bytes past the base, no further descriptor is fetched and the walk ends.
- R7: Each data request (`mem_req_data`=1) has a length equal to the smaller of the remaining buffer bytes and the remaining region bytes. It targets the current region address. The region address then advances by that length, and both remaining counts drop by it.
- R8: Data requests carry `mem_req_write` equal to the latched direction: 1 means data goes into host memory, 0 means it is read from host memory.
- R9: When the remaining count reaches zero, `done` pulses for one cycle and the block goes idle. With a zero start count, `done` pulses two cycles after `start` is sampled and no request is issued.
- R10: When the table ends while bytes remain, `incomplete` pulses for one cycle instead of `done`.
- R11: At most one request is outstanding. A request held without `mem_req_ready` keeps its address, length and kind stable. No new request is raised until the previous one has been answered.
- R12: A new transfer clears the region address, region length and final flag, and reloads the pointer from the base. Region bytes left over from the previous transfer are never used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (sampled while idle) |
| start_base | input | 32 | Table base address, bits [1:0] ignored |
| start_to_mem | input | 1 | 1: data goes into host memory, 0: data comes from host memory |
| start_count | input | CNT_W | Buffer byte count |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse: whole buffer moved |
| incomplete | output | 1 | One-cycle pulse: table ended first |
| mem_req_valid | output | 1 | Request valid |
| mem_req_ready | input | 1 | Request accepted when high with valid |
| mem_req_data | output | 1 | 1: data chunk, 0: descriptor word read |
| mem_req_write | output | 1 | Direction of a data chunk into memory |
| mem_req_addr | output | 32 | Request address |
| mem_req_len | output | 17 | Request length in bytes |
| mem_rsp_valid | input | 1 | Response for the accepted request |
| mem_rsp_data | input | 32 | Descriptor word for descriptor reads |

## Verification
With `start` sampled at edge 1, `busy` is high after that edge. After edge 2, either `done` is high (zero count) or the first descriptor read at the base is valid. The bench samples exactly at those two falling edges. Later requests depend on random ready stalls and response delays of zero to two cycles, so their timing is not fixed. Each accepted request is compared in order against a list built by a bench model of the walk. The closing pulse is awaited, then checked for kind, and the number of requests seen is compared with the model's count.

// File: rtl/sg_table_walker.sv
module sg_table_walker #(
  parameter int CNT_W      = 24,
  parameter int PAGE_BYTES = 4096,
  parameter int DESC_BYTES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [31:0]      start_base,
  input  logic             start_to_mem,
  input  logic [CNT_W-1:0] start_count,
  output logic             busy,
  output logic             done,
  output logic             incomplete,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_data,
  output logic             mem_req_write,
  output logic [31:0]      mem_req_addr,
  output logic [16:0]      mem_req_len,
  input  logic             mem_rsp_valid,
  input  logic [31:0]      mem_rsp_data
);
  localparam int LEN_W = 17;
  localparam logic [LEN_W-1:0] MAX_REGION = LEN_W'(65536);
  localparam logic [LEN_W-1:0] WORD_LEN   = LEN_W'(4);
  localparam logic [31:0] PAGE_LIM  = 32'(PAGE_BYTES);
  localparam logic [31:0] DESC_STEP = 32'(DESC_BYTES);
  localparam logic [31:0] HI_OFS    = 32'(4);

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_DLO, S_WLO, S_DHI, S_WHI, S_DATA, S_WDATA
  } state_t;

  state_t           state;
  logic [31:0]      base, ptr, raddr, lo_word;
  logic [LEN_W-1:0] rlen;
  logic             last, dir;
  logic [CNT_W-1:0] rem;

  logic [LEN_W-1:0] chunk, size_len;
  logic             table_end;

  assign chunk     = (rem < CNT_W'(rlen)) ? rem[LEN_W-1:0] : rlen;
  assign size_len  = (mem_rsp_data[15:1] == '0) ? MAX_REGION
                                                : {1'b0, mem_rsp_data[15:1], 1'b0};
  assign table_end = last || ((ptr - base) >= PAGE_LIM);

  assign busy          = (state != S_IDLE);
  assign mem_req_valid = (state == S_DLO) || (state == S_DHI) || (state == S_DATA);
  assign mem_req_data  = (state == S_DATA);
  assign mem_req_write = (state == S_DATA) && dir;
  assign mem_req_len   = (state == S_DATA) ? chunk : WORD_LEN;

  always_comb begin
    case (state)
      S_DLO:   mem_req_addr = ptr;
      S_DHI:   mem_req_addr = ptr + HI_OFS;
      S_DATA:  mem_req_addr = raddr;
      default: mem_req_addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      base       <= '0;
      ptr        <= '0;
      raddr      <= '0;
      lo_word    <= '0;
      rlen       <= '0;
      last       <= 1'b0;
      dir        <= 1'b0;
      rem        <= '0;
      done       <= 1'b0;
      incomplete <= 1'b0;
    end else begin
      done       <= 1'b0;
      incomplete <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          base  <= {start_base[31:2], 2'b00};
          ptr   <= {start_base[31:2], 2'b00};
          raddr <= '0;
          rlen  <= '0;
          last  <= 1'b0;
          rem   <= start_count;
          dir   <= start_to_mem;
          state <= S_CHECK;
        end
        S_CHECK: begin
          if (rem == '0) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else if (rlen == '0) begin
            if (table_end) begin
              incomplete <= 1'b1;
              state      <= S_IDLE;
            end else begin
              state <= S_DLO;
            end
          end else begin
            state <= S_DATA;
          end
        end
        S_DLO: if (mem_req_ready) state <= S_WLO;
        S_WLO: if (mem_rsp_valid) begin
          lo_word <= mem_rsp_data;
          state   <= S_DHI;
        end
        S_DHI: if (mem_req_ready) state <= S_WHI;
        S_WHI: if (mem_rsp_valid) begin
          raddr <= lo_word;
          rlen  <= size_len;
          last  <= mem_rsp_data[31];
          ptr   <= ptr + DESC_STEP;
          state <= S_CHECK;
        end
        S_DATA: if (mem_req_ready) state <= S_WDATA;
        S_WDATA: if (mem_rsp_valid) begin
          raddr <= raddr + 32'(chunk);
          rlen  <= rlen - chunk;
          rem   <= rem - CNT_W'(chunk);
          state <= S_CHECK;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_one_outstanding_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

  p_hold_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_len) && $stable(mem_req_data)));

  p_len_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_data) |-> (mem_req_len != '0 && mem_req_len <= MAX_REGION));

  p_desc_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_data) |->
      (!mem_req_write && mem_req_len == WORD_LEN && mem_req_addr[1:0] == 2'b00));

  p_end_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && incomplete));

  p_end_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done || incomplete) |-> !busy);

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
endmodule

// File: tb/tb_sg_table_walker.sv
`timescale 1ns/1ps
module tb_sg_table_walker;
  localparam int CNT_W = 24;
  localparam int EMAX  = 2048;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, start_to_mem = 1'b0;
  logic [31:0] start_base = '0;
  logic [CNT_W-1:0] start_count = '0;
  logic busy, done, incomplete;
  logic mem_req_valid, mem_req_data, mem_req_write;
  logic mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic [16:0] mem_req_len;
  logic mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  always #2.5 clk = ~clk;

  sg_table_walker #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_base(start_base),
    .start_to_mem(start_to_mem), .start_count(start_count), .busy(busy),
    .done(done), .incomplete(incomplete), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_data(mem_req_data),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_len(mem_req_len), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data));

  int checks = 0, failures = 0;
  logic [31:0] d_lo [0:15];
  logic [31:0] d_hi [0:15];
  logic [31:0] cur_base = '0;
  bit fs_mode = 1'b0;
  logic [50:0] e_req [0:EMAX-1];
  int e_n = 0, e_outcome = 0, e_desc = 0;
  int got_n = 0, got_desc = 0, got_done = 0, got_inc = 0;
  bit pend = 1'b0;
  int dly = 0;
  logic [31:0] pend_data = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] desc_word(input logic [31:0] a);
    logic [31:0] off = a - cur_base;
    int idx = int'(off >> 3);
    if (fs_mode) return off[2] ? 32'h0000_0002 : (32'h1000_0000 + 32'(idx) * 32'h10);
    if (idx > 15) return 32'h0;
    return off[2] ? d_hi[idx] : d_lo[idx];
  endfunction

  task automatic push(input bit kind, input bit wr, input logic [31:0] a, input int len);
    if (e_n < EMAX) e_req[e_n] = {kind, wr, a, 17'(len)};
    e_n++;
    if (!kind) e_desc++;
  endtask

  task automatic model(input logic [31:0] base, input bit wr, input int count);
    logic [31:0] ptr = base, raddr = 0, lo, hi;
    int rlen = 0, rem = count, ch;
    bit last = 0;
    e_n = 0; e_desc = 0;
    while (1) begin
      if (rem == 0) begin e_outcome = 1; break; end
      if (rlen == 0) begin
        if (last || (ptr - base) >= 32'd4096) begin e_outcome = 2; break; end
        lo = desc_word(ptr); hi = desc_word(ptr + 4);
        push(0, 0, ptr, 4); push(0, 0, ptr + 4, 4);
        ptr += 8;
        raddr = lo;
        rlen = int'({hi[15:1], 1'b0});
        if (rlen == 0) rlen = 65536;
        last = hi[31];
      end
      ch = (rem < rlen) ? rem : rlen;
      push(1, wr, raddr, ch);
      raddr += 32'(ch); rlen -= ch; rem -= ch;
    end
  endtask

  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (pend) begin
      if (dly == 0) begin mem_rsp_valid = 1'b1; mem_rsp_data = pend_data; pend = 1'b0; end
      else dly--;
    end
    mem_req_ready = ($urandom_range(0, 3) != 0);
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (got_n < e_n && got_n < EMAX)
        chk({mem_req_data, mem_req_write, mem_req_addr, mem_req_len} == e_req[got_n],
            mem_req_data ? "R7 R8" : "R3", "request{kind,wr,addr,len}",
            64'({mem_req_data, mem_req_write, mem_req_addr, mem_req_len}), 64'(e_req[got_n]));
      else
        chk(1'b0, "R5 R11", "extra request addr", 64'(mem_req_addr), 64'(0));
      if (!mem_req_data) got_desc++;
      got_n++;
      pend = 1'b1;
      dly = $urandom_range(0, 2);
      pend_data = mem_req_data ? 32'h0 : desc_word(mem_req_addr);
    end
    if (done) got_done++;
    if (incomplete) got_inc++;
  end

  task automatic run_xfer(input logic [31:0] base, input bit wr, input int count,
                          input bit mid_start, input string tag);
    int t = 0;
    cur_base = {base[31:2], 2'b00};
    model(cur_base, wr, count);
    got_n = 0; got_desc = 0; got_done = 0; got_inc = 0;
    @(negedge clk);
    start = 1'b1; start_base = base; start_to_mem = wr; start_count = CNT_W'(count);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2", "busy after start", 64'(busy), 64'(1));
    @(negedge clk);
    if (count == 0)
      chk(done == 1'b1 && !mem_req_valid, "R9", "zero-count done", 64'({done, mem_req_valid}), 64'(2));
    else
      chk(mem_req_valid && !mem_req_data && mem_req_addr == cur_base, "R3",
          "first read at base", 64'({mem_req_valid, mem_req_data, mem_req_addr}), 64'({1'b1, 1'b0, cur_base}));
    if (mid_start && busy) begin
      start = 1'b1; start_base = base + 32'h100; start_to_mem = !wr; start_count = 24'h7;
      @(negedge clk);
      start = 1'b0;
    end
    while (got_done + got_inc == 0 && t < 60000) begin @(negedge clk); t++; end
    @(negedge clk);
    chk(got_done == (e_outcome == 1) && got_inc == (e_outcome == 2),
        e_outcome == 1 ? "R9" : "R10", {tag, " outcome"},
        64'({got_done[7:0], got_inc[7:0]}), 64'({8'(e_outcome == 1), 8'(e_outcome == 2)}));
    chk(got_n == e_n, "R5 R6", {tag, " request count"}, 64'(got_n), 64'(e_n));
    chk(!busy, "R9", {tag, " idle after end"}, 64'(busy), 64'(0));
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    chk(1'b0, "R11", "watchdog expired", 64'(0), 64'(1));
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) begin d_lo[i] = '0; d_hi[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !incomplete && !mem_req_valid, "R1", "reset state",
        64'({busy, done, incomplete, mem_req_valid}), 64'(0));

    run_xfer(32'h0000_4000, 1'b1, 0, 1'b0, "zero count R9");

    d_lo[0] = 32'hA000_0000; d_hi[0] = 32'h8000_0011;
    run_xfer(32'h0000_5000, 1'b0, 16, 1'b0, "odd size bit R4");

    d_lo[0] = 32'hB000_0000; d_hi[0] = 32'h8000_0001;
    run_xfer(32'h0000_6000, 1'b1, 70000, 1'b0, "zero length R4 R10");

    d_lo[0] = 32'hC000_0000; d_hi[0] = 32'h0000_0100;
    d_lo[1] = 32'hC100_0000; d_hi[1] = 32'h8000_0040;
    run_xfer(32'h0000_7000, 1'b1, 48, 1'b0, "partial region R7");
    run_xfer(32'h0000_7000, 1'b0, 300, 1'b0, "fresh restart R12");

    d_lo[0] = 32'hD000_0000; d_hi[0] = 32'h0000_0020;
    d_lo[1] = 32'hD100_0000; d_hi[1] = 32'h8000_0020;
    d_lo[2] = 32'hDEAD_0000; d_hi[2] = 32'h8000_0100;
    run_xfer(32'h0000_8000, 1'b1, 200, 1'b0, "last stops fetch R5 R10");

    d_lo[0] = 32'hE000_0000; d_hi[0] = 32'h0000_0200;
    d_lo[1] = 32'hE100_0000; d_hi[1] = 32'h8000_0200;
    run_xfer(32'h0000_9000, 1'b1, 600, 1'b1, "start while busy R2");

    fs_mode = 1'b1;
    run_xfer(32'h0001_0000, 1'b0, 5000, 1'b0, "page fail-safe R6");
    chk(got_desc == 1024, "R6", "descriptor reads before fail-safe", 64'(got_desc), 64'(1024));
    fs_mode = 1'b0;

    for (int n = 0; n < 30; n++) begin
      int nd = $urandom_range(1, 6);
      int total = 0;
      int cnt;
      for (int i = 0; i < nd; i++) begin
        int len = ($urandom_range(0, 7) == 0) ? 0 : $urandom_range(1, 512);
        d_lo[i] = $urandom;
        d_hi[i] = {(i == nd - 1), 15'($urandom), 16'(len)};
        total += (len & 32'hFFFE) == 0 ? 65536 : (len & 32'hFFFE);
      end
      cnt = ($urandom_range(0, 3) == 0) ? total : $urandom_range(0, 2048);
      run_xfer({$urandom_range(1, 255), 12'h0} + 32'($urandom_range(0, 255)) * 4,
               1'($urandom), cnt, 1'b0, "random R7 R8");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule